// File: doc/BRIEF.md
# Windowed Display RAM Address Generator

This block turns a stream of pixel bytes into write cycles for a display memory of 80 lines by 64 bytes. Each byte packs two 4-bit pixels, so one line holds 128 pixels and the whole memory holds 5120 bytes. The block keeps a current column and a current line. Both stay inside a rectangular window that the command parser sets.

The command parser supplies four window bounds and a one-cycle load strobe. A load moves the position to the window's first column and first line. After that, every accepted byte is written at the current position, and the position then advances. In row-major order the column moves first and carries into the line. In column-major order the line moves first and carries into the column. Either coordinate that steps past its window end returns to its window start.

The write enable, the address and the data are registered. They appear one clock after the byte is accepted. A memory with one synchronous write port can take them directly.

Top module: `disp_addr_gen`

## Requirements
- R1: One clock after a cycle with `byte_valid` high, `wr_en` is high, `wr_data` equals the accepted byte, and `wr_addr` equals column + 64 × line of the position held when the byte was accepted. One clock after a cycle with `byte_valid` low, `wr_en` is low.
- R2: With `vert_mode` = 0, each accepted byte advances the column by one.
- R3: With `vert_mode` = 0, when the column steps past the window's last column, it returns to the window's first column and the line advances by one.
- R4: With `vert_mode` = 0, when the line steps past the window's last line, it returns to the window's first line.
- R5: With `vert_mode` = 1, each accepted byte advances the line first. When the line steps past its window end, it returns to the window's first line and the column advances. When the column then steps past its end, it returns to the window's first column.
- R6: A cycle with `win_load` high stores the four bounds and moves the position to the new first column and first line. This takes priority over any step. A byte accepted in that same cycle is written at the position held before the load.
- R7: Line bounds of 80 or more are reduced modulo 80 when loaded. For example, 85 is stored as 5. Column bounds use their 6 bits unchanged, which covers 0 to 63.
- R8: After reset, the window covers columns 0 to 63 and lines 0 to 79, the position is column 0, line 0, and `wr_en` is low.
- R9: In a cycle with neither `byte_valid` nor `win_load`, the position does not change.
- R10: If a window start lies beyond its end, every step of that coordinate wraps at once back to its start and carries into the other coordinate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_load | input | 1 | Load window bounds and jump to the window start |
| win_col_lo | input | 6 | Window first column |
| win_col_hi | input | 6 | Window last column |
| win_row_lo | input | 7 | Window first line (reduced modulo 80) |
| win_row_hi | input | 7 | Window last line (reduced modulo 80) |
| vert_mode | input | 1 | 0: column steps first, 1: line steps first |
| byte_valid | input | 1 | A pixel byte is offered this cycle |
| byte_in | input | 8 | Pixel byte |
| wr_en | output | 1 | Memory write enable |
| wr_addr | output | 13 | Memory byte address |
| wr_data | output | 8 | Memory write data |

## Verification
A wrong position register or a wrong window bound shows up as a bad `wr_addr` on the very next write. The error does not stay hidden until some later frame. Wrap and carry errors appear only at window edges. For that reason the stimulus uses narrow windows, windows that end at column 63 or line 79, and windows whose start lies beyond their end. These cases force an edge on almost every byte. A wrong priority between load and step shows on the first write after the load, which must land exactly at the window start.

// File: rtl/disp_addr_pkg.sv
package disp_addr_pkg;

  // Stepping order of the write pointer.
  typedef enum logic {
    STEP_ALONG_ROW = 1'b0,  // column first, carry into line
    STEP_ALONG_COL = 1'b1   // line first, carry into column
  } step_order_e;

endpackage

// File: rtl/dag_window_regs.sv
module dag_window_regs #(
  parameter int NUM_COLS = 64,
  parameter int NUM_ROWS = 80,
  parameter int COL_W    = 6,
  parameter int ROW_W    = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [COL_W-1:0] col_lo_in,
  input  logic [COL_W-1:0] col_hi_in,
  input  logic [ROW_W-1:0] row_lo_in,
  input  logic [ROW_W-1:0] row_hi_in,
  output logic [COL_W-1:0] col_lo_fold,
  output logic [ROW_W-1:0] row_lo_fold,
  output logic [COL_W-1:0] col_lo,
  output logic [COL_W-1:0] col_hi,
  output logic [ROW_W-1:0] row_lo,
  output logic [ROW_W-1:0] row_hi
);

  localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COLS - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);

  logic [COL_W-1:0] col_hi_fold;
  logic [ROW_W-1:0] row_hi_fold;

  // Bring out-of-range bounds back inside the memory.
  always_comb begin
    col_lo_fold = COL_W'(int'(col_lo_in) % NUM_COLS);
    col_hi_fold = COL_W'(int'(col_hi_in) % NUM_COLS);
    row_lo_fold = ROW_W'(int'(row_lo_in) % NUM_ROWS);
    row_hi_fold = ROW_W'(int'(row_hi_in) % NUM_ROWS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_lo <= '0;
      col_hi <= COL_LAST;
      row_lo <= '0;
      row_hi <= ROW_LAST;
    end else if (load) begin
      col_lo <= col_lo_fold;
      col_hi <= col_hi_fold;
      row_lo <= row_lo_fold;
      row_hi <= row_hi_fold;
    end
  end

  AST_ROW_BOUNDS_FOLDED: assert property (@(posedge clk) disable iff (rst)
    (int'(row_lo) < NUM_ROWS) && (int'(row_hi) < NUM_ROWS)); // R7

endmodule

// File: rtl/dag_axis_step.sv
module dag_axis_step #(
  parameter int W = 6
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic         adv,
  output logic [W-1:0] nxt,
  output logic         past_end
);

  logic [W:0] bumped;

  // past_end reports whether a step would leave the window, whether or not
  // the step is taken. The caller uses it as the carry into the other axis.
  always_comb begin
    bumped   = {1'b0, cur} + {{W{1'b0}}, 1'b1};
    past_end = (bumped > {1'b0, hi});
    if (!adv)          nxt = cur;
    else if (past_end) nxt = lo;
    else               nxt = bumped[W-1:0];
  end

endmodule

// File: rtl/dag_write_port.sv
module dag_write_port #(
  parameter int NUM_COLS = 64,
  parameter int COL_W    = 6,
  parameter int ROW_W    = 7,
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [COL_W-1:0]  col,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  logic [ADDR_W-1:0] lin_addr;

  always_comb begin
    lin_addr = ADDR_W'(col) + ADDR_W'(row) * ADDR_W'(NUM_COLS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en   <= valid;
      wr_addr <= lin_addr;
      wr_data <= data;
    end
  end

  AST_WREN_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (rst)
    valid |=> wr_en); // R1
  AST_NO_SPURIOUS_WRITE: assert property (@(posedge clk) disable iff (rst)
    !valid |=> !wr_en); // R1
  AST_DATA_PASSES: assert property (@(posedge clk) disable iff (rst)
    valid |=> (wr_data == $past(data))); // R1

endmodule

// File: rtl/disp_addr_gen.sv
module disp_addr_gen
  import disp_addr_pkg::*;
#(
  parameter int NUM_COLS = 64,
  parameter int NUM_ROWS = 80,
  parameter int DATA_W   = 8,
  localparam int COL_W   = $clog2(NUM_COLS),
  localparam int ROW_W   = $clog2(NUM_ROWS),
  localparam int ADDR_W  = $clog2(NUM_COLS * NUM_ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_load,
  input  logic [COL_W-1:0]  win_col_lo,
  input  logic [COL_W-1:0]  win_col_hi,
  input  logic [ROW_W-1:0]  win_row_lo,
  input  logic [ROW_W-1:0]  win_row_hi,
  input  logic              vert_mode,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_in,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  step_order_e      order;
  logic [COL_W-1:0] col_q, col_nxt, col_lo, col_hi, col_lo_fold;
  logic [ROW_W-1:0] row_q, row_nxt, row_lo, row_hi, row_lo_fold;
  logic             col_adv, row_adv, col_past, row_past;

  dag_window_regs #(
    .NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS), .COL_W(COL_W), .ROW_W(ROW_W)
  ) win_i (
    .clk(clk), .rst(rst), .load(win_load),
    .col_lo_in(win_col_lo), .col_hi_in(win_col_hi),
    .row_lo_in(win_row_lo), .row_hi_in(win_row_hi),
    .col_lo_fold(col_lo_fold), .row_lo_fold(row_lo_fold),
    .col_lo(col_lo), .col_hi(col_hi), .row_lo(row_lo), .row_hi(row_hi)
  );

  // The primary axis steps on every byte. The secondary axis steps only
  // when the primary axis leaves its window.
  always_comb begin
    order = step_order_e'(vert_mode);
    if (order == STEP_ALONG_ROW) begin
      col_adv = byte_valid;
      row_adv = byte_valid & col_past;
    end else begin
      row_adv = byte_valid;
      col_adv = byte_valid & row_past;
    end
  end

  dag_axis_step #(.W(COL_W)) col_step_i (
    .cur(col_q), .lo(col_lo), .hi(col_hi), .adv(col_adv),
    .nxt(col_nxt), .past_end(col_past)
  );

  dag_axis_step #(.W(ROW_W)) row_step_i (
    .cur(row_q), .lo(row_lo), .hi(row_hi), .adv(row_adv),
    .nxt(row_nxt), .past_end(row_past)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q <= '0;
      row_q <= '0;
    end else if (win_load) begin
      col_q <= col_lo_fold;
      row_q <= row_lo_fold;
    end else begin
      col_q <= col_nxt;
      row_q <= row_nxt;
    end
  end

  // The write uses the position held before the step.
  dag_write_port #(
    .NUM_COLS(NUM_COLS), .COL_W(COL_W), .ROW_W(ROW_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) wport_i (
    .clk(clk), .rst(rst), .valid(byte_valid), .col(col_q), .row(row_q),
    .data(byte_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  AST_COL_IN_MEMORY: assert property (@(posedge clk) disable iff (rst)
    int'(col_q) < NUM_COLS); // R3
  AST_ROW_IN_MEMORY: assert property (@(posedge clk) disable iff (rst)
    int'(row_q) < NUM_ROWS); // R4
  AST_LOAD_SETS_ROW: assert property (@(posedge clk) disable iff (rst)
    win_load |=> (int'(row_q) == int'($past(win_row_lo)) % NUM_ROWS)); // R6
  AST_LOAD_SETS_COL: assert property (@(posedge clk) disable iff (rst)
    win_load |=> (int'(col_q) == int'($past(win_col_lo)) % NUM_COLS)); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!win_load && !byte_valid) |=> ($stable(col_q) && $stable(row_q))); // R9
  AST_ADDR_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> (int'(wr_addr) ==
      int'($past(col_q)) + NUM_COLS * int'($past(row_q)))); // R1

endmodule

// File: tb/disp_addr_gen_tb.sv
module disp_addr_gen_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       win_load = 1'b0;
  logic [5:0] win_col_lo = '0, win_col_hi = '0;
  logic [6:0] win_row_lo = '0, win_row_hi = '0;
  logic       vert_mode = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_in = '0;
  logic        wr_en;
  logic [12:0] wr_addr;
  logic [7:0]  wr_data;

  int n_cmp  = 0;
  int n_bad  = 0;
  int cycles = 0;

  // Reference model state
  int m_col = 0, m_row = 0;
  int m_cs = 0, m_ce = 63, m_rs = 0, m_re = 79;

  disp_addr_gen dut_i (
    .clk(clk), .rst(rst), .win_load(win_load),
    .win_col_lo(win_col_lo), .win_col_hi(win_col_hi),
    .win_row_lo(win_row_lo), .win_row_hi(win_row_hi),
    .vert_mode(vert_mode), .byte_valid(byte_valid), .byte_in(byte_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected under %0d", cycles, WATCHDOG);
      summary_and_end();
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Drive one cycle, then compare the registered outputs with the model.
  task automatic cyc(string tag, bit ld, int cl, int ch, int rl, int rh,
                     bit vm, bit v, int d);
    int e_addr;
    @(negedge clk);
    win_load = ld; win_col_lo = 6'(cl); win_col_hi = 6'(ch);
    win_row_lo = 7'(rl); win_row_hi = 7'(rh);
    vert_mode = vm; byte_valid = v; byte_in = 8'(d);
    e_addr = m_col + 64 * m_row;
    @(posedge clk);
    #1;
    check(tag, "wr_en", int'(wr_en), int'(v));
    if (v) begin
      check(tag, "wr_addr", int'(wr_addr), e_addr);
      check(tag, "wr_data", int'(wr_data), d & 255);
    end
    if (ld) begin
      m_cs = cl % 64; m_ce = ch % 64; m_rs = (rl % 128) % 80; m_re = (rh % 128) % 80;
      m_col = m_cs; m_row = m_rs;
    end else if (v) begin
      if (!vm) begin
        m_col++;
        if (m_col > m_ce) begin
          m_col = m_cs; m_row++;
          if (m_row > m_re) m_row = m_rs;
        end
      end else begin
        m_row++;
        if (m_row > m_re) begin
          m_row = m_rs; m_col++;
          if (m_col > m_ce) m_col = m_cs;
        end
      end
    end
  endtask

  task automatic load(string tag, int cl, int ch, int rl, int rh);
    cyc(tag, 1'b1, cl, ch, rl, rh, 1'b0, 1'b0, 0);
  endtask

  task automatic bytes(string tag, bit vm, int n);
    for (int i = 0; i < n; i++) cyc(tag, 1'b0, 0, 0, 0, 0, vm, 1'b1, (i * 37 + 5));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R8", "wr_en in reset", int'(wr_en), 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R8", "wr_en after reset", int'(wr_en), 0);
    // R8: first write of the full window lands at 0; R2/R3 cross column 63
    bytes("R8", 1'b0, 1);
    bytes("R2", 1'b0, 60);
    bytes("R3", 1'b0, 10);
    // R9: idle cycles keep position
    for (int i = 0; i < 5; i++) cyc("R9", 1'b0, 0, 0, 0, 0, 1'b0, 1'b0, 0);
    bytes("R9", 1'b0, 2);
    // R4/R6: small window, wrap of line back to start
    load("R6", 2, 4, 3, 5);
    bytes("R6", 1'b0, 1);
    bytes("R4", 1'b0, 14);
    // R5: column-major stepping at the bottom edge and column 63
    load("R5", 61, 63, 77, 79);
    bytes("R5", 1'b1, 12);
    // R7: line bounds above 79 folded
    load("R7", 5, 6, 85, 87);
    bytes("R7", 1'b0, 8);
    // R6: load with a concurrent byte goes to the old position
    bytes("R6", 1'b0, 3);
    cyc("R6", 1'b1, 30, 32, 40, 41, 1'b0, 1'b1, 8'hA5);
    bytes("R6", 1'b0, 2);
    // R10: start beyond end, both orders
    load("R10", 20, 5, 50, 52);
    bytes("R10", 1'b0, 6);
    load("R10", 7, 9, 70, 60);
    bytes("R10", 1'b1, 6);
    // R1: mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 4)
        cyc("R1", 1'b1, $urandom_range(0, 63), $urandom_range(0, 63),
            $urandom_range(0, 127), $urandom_range(0, 127),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom_range(0, 255));
      else
        cyc("R1", 1'b0, 0, 0, 0, 0, 1'($urandom_range(0, 1)),
            1'(r < 75), $urandom_range(0, 255));
    end
    summary_and_end();
  end

endmodule